// File: doc/BRIEF.md
# Receiver Collision Request Grant Controller

This block is the per-node logic that relieves a destination node when too many ring nodes send to it at once. Each slot that passes the node carries a collision-address field made of a 2-bit control code and a destination address. The node counts slots in which a queued packet could not be delivered. When that count reaches a tolerance, the node claims the field with a request naming the congested destination and becomes the tail of a congestion path. Nodes that see the request become limited for that destination. The destination itself answers with a satisfied token, and limited nodes hold that token until they have used their quota. When the token reaches the tail, the tail turns it into a grant, and the grant returns every node on the path to free access.

The node updates its header rewrite once per slot, one clock after the slot strobe. The transmit-enable mask, one bit per destination, is combinational. It clears only the bit of the congested destination, and only while the node is limited and has no more right to send there. All other destinations stay enabled. The mode is brought out so the surrounding node logic can observe it.

Top module: `cgc_node_ctrl`

## Requirements
- R1: After reset the mode is free access (code 0), every mask bit is 1, the header-output strobe is 0 and the output control code is 0.
- R2: Control codes are 0 none, 1 request, 2 satisfied, 3 grant. The mode codes are 0 free, 1 tail, 2 limited, 3 head. In a slot that needs no action, the incoming code and destination are copied to the output one clock after the strobe.
- R3: In free mode, a slot that is blocked, has no delivery and follows QD-1 counted blocked slots makes the node write a request for the blocked destination if the incoming field is empty. The node then enters tail mode.
- R4: A slot with a delivery clears the blocked-slot count, so blocked runs split by a delivery never raise a request.
- R5: If the count has reached QD but the incoming field is occupied, the node forwards the field unchanged. It writes the request in the next slot whose field is empty, even if that slot is not blocked.
- R6: A free node that sees a request for another destination forwards it and enters limited mode for that destination.
- R7: In limited mode the mask bit of the limited destination is 1 while that destination's queue is non-empty and fewer than QUOTA packets have been sent to it. Otherwise the bit is 0. Every other mask bit is always 1, and outside limited mode all bits are 1.
- R8: A limited node that is still active absorbs a satisfied token for its destination (output code 0). It re-emits the token in the first later slot with an empty field once it has become inactive. An inactive limited node forwards the token unchanged.
- R9: A free node that sees a request naming its own address writes a satisfied token with its own address and enters head mode. A head node consumes a grant for its own address (output code 0) and returns to free mode.
- R10: A tail node that receives a satisfied token for its destination rewrites it as a grant for that destination and returns to free mode. Tokens for other destinations are forwarded, and the node stays in tail mode.
- R11: A limited node that sees a grant for its destination forwards it, returns to free mode and clears its send count, so a later limited period starts with the full quota.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| my_addr | input | NODE_W | Address of this node |
| slot_valid | input | 1 | A slot header is present this cycle |
| hdr_cmsg_in | input | 2 | Incoming control code |
| hdr_cdest_in | input | NODE_W | Incoming collision destination |
| blocked | input | 1 | A queued packet could not be delivered in this slot |
| blocked_dest | input | NODE_W | Destination of the blocked packet |
| tx_done | input | 1 | This node delivered a packet in this slot |
| tx_dest | input | NODE_W | Destination of the delivered packet |
| q_nonempty | input | 2**NODE_W | Per-destination queue holds packets |
| hdr_out_valid | output | 1 | Rewritten header is valid |
| hdr_cmsg_out | output | 2 | Outgoing control code |
| hdr_cdest_out | output | NODE_W | Outgoing collision destination |
| tx_en_mask | output | 2**NODE_W | Per-destination transmit enable |
| ctl_state | output | 2 | Current mode code |

## Verification
The bench builds the block with NODE_W=3, QD=3 and QUOTA=2. With these values starvation builds up in three slots, the quota runs out after two sends, and all eight mask bits can be seen at once. Short directed slot sequences therefore reach every mode change, including a held token, a deferred request and a fresh quota after a grant.

// File: rtl/cgc_pkg.sv
// Shared codes for the collision request/grant controller.
// Assumes a 2-bit control code in the collision-address field.
package cgc_pkg;
    typedef enum logic [1:0] {
        MSG_NONE = 2'd0,
        MSG_REQ  = 2'd1,
        MSG_SAT  = 2'd2,
        MSG_GNT  = 2'd3
    } msg_e;

    typedef enum logic [1:0] {
        MODE_FREE    = 2'd0,
        MODE_TAIL    = 2'd1,
        MODE_LIMITED = 2'd2,
        MODE_HEAD    = 2'd3
    } mode_e;
endpackage

// File: rtl/cgc_delay_counter.sv
// Counts consecutive undelivered slots while the node is in free access.
// Flags starvation once QD blocked slots have gone by without a delivery.
// Assumes QD >= 1. Clears on delivery, when disabled, or when the request is written.
module cgc_delay_counter #(
    parameter int NODE_W = 4,
    parameter int QD     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic              slot_valid,
    input  logic              blocked,
    input  logic [NODE_W-1:0] blocked_dest,
    input  logic              delivered,
    input  logic              clear,
    output logic              starved,
    output logic [NODE_W-1:0] starve_dest
);
    localparam int CNT_W = $clog2(QD + 1);
    localparam logic [CNT_W-1:0] QD_V  = CNT_W'(QD);
    localparam logic [CNT_W-1:0] QD_M1 = CNT_W'(QD - 1);

    logic [CNT_W-1:0]  c_q;
    logic [NODE_W-1:0] cand_q;

    // Starvation: limit already reached, or reached by this blocked slot.
    always_comb begin
        starved = count_en && slot_valid && !delivered &&
                  ((c_q >= QD_V) || (blocked && c_q == QD_M1));
        starve_dest = blocked ? blocked_dest : cand_q;
    end

    // Blocked-slot count, saturating at QD.
    always_ff @(posedge clk) begin
        if (!rst_n || !count_en) begin
            c_q <= '0;
        end else if (slot_valid) begin
            if (clear || delivered)
                c_q <= '0;
            else if (blocked && c_q < QD_V)
                c_q <= c_q + 1'b1;
        end
    end

    // Remember the most recent blocked destination.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cand_q <= '0;
        else if (slot_valid && blocked)
            cand_q <= blocked_dest;
    end
endmodule

// File: rtl/cgc_quota_tracker.sv
// Tracks packets sent to the limited destination and builds the transmit mask.
// Assumes QUOTA >= 1. The count is cleared whenever the node is not limited.
module cgc_quota_tracker #(
    parameter int NODE_W = 4,
    parameter int QUOTA  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   slot_valid,
    input  logic                   limited,
    input  logic [NODE_W-1:0]      lim_dest,
    input  logic                   tx_done,
    input  logic [NODE_W-1:0]      tx_dest,
    input  logic [(1<<NODE_W)-1:0] q_nonempty,
    output logic                   lim_active,
    output logic [(1<<NODE_W)-1:0] tx_en_mask
);
    localparam int NDEST = 1 << NODE_W;
    localparam int QW    = $clog2(QUOTA + 1);
    localparam logic [QW-1:0] QUOTA_V = QW'(QUOTA);

    logic [QW-1:0] sent_q;

    // Active while packets wait for the limited destination and quota remains.
    always_comb lim_active = limited && q_nonempty[lim_dest] && (sent_q < QUOTA_V);

    // Per-destination enable: only the limited destination can be barred.
    for (genvar d = 0; d < NDEST; d++) begin : g_mask
        assign tx_en_mask[d] = !(limited && !lim_active && (lim_dest == NODE_W'(d)));
    end

    // Count sends to the limited destination.
    always_ff @(posedge clk) begin
        if (!rst_n || !limited)
            sent_q <= '0;
        else if (slot_valid && tx_done && tx_dest == lim_dest && sent_q < QUOTA_V)
            sent_q <= sent_q + 1'b1;
    end
endmodule

// File: rtl/cgc_ctrl_fsm.sv
// Mode machine and header rewrite for the request/satisfied/grant exchange.
// Acts once per strobed slot; the rewritten field is registered.
module cgc_ctrl_fsm
    import cgc_pkg::*;
#(
    parameter int NODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_valid,
    input  logic [NODE_W-1:0] my_addr,
    input  logic [1:0]        hdr_cmsg_in,
    input  logic [NODE_W-1:0] hdr_cdest_in,
    input  logic              starved,
    input  logic [NODE_W-1:0] starve_dest,
    input  logic              lim_active,
    output mode_e             mode,
    output logic [NODE_W-1:0] lim_dest,
    output logic              req_written,
    output logic              hdr_out_valid,
    output logic [1:0]        hdr_cmsg_out,
    output logic [NODE_W-1:0] hdr_cdest_out
);
    mode_e             mode_q, mode_n;
    logic [NODE_W-1:0] dest_q, dest_n;
    logic              hold_q, hold_n;
    msg_e              msg_in, msg_n;
    logic [NODE_W-1:0] cdest_n;

    assign msg_in   = msg_e'(hdr_cmsg_in);
    assign mode     = mode_q;
    assign lim_dest = dest_q;

    // Next mode, held-token flag and header rewrite for the current slot.
    always_comb begin
        mode_n      = mode_q;
        dest_n      = dest_q;
        hold_n      = hold_q;
        msg_n       = msg_in;
        cdest_n     = hdr_cdest_in;
        req_written = 1'b0;
        if (slot_valid) begin
            unique case (mode_q)
                MODE_FREE: begin
                    if (msg_in == MSG_REQ && hdr_cdest_in == my_addr) begin
                        mode_n  = MODE_HEAD;
                        dest_n  = my_addr;
                        msg_n   = MSG_SAT;
                        cdest_n = my_addr;
                    end else if (msg_in == MSG_REQ) begin
                        mode_n = MODE_LIMITED;
                        dest_n = hdr_cdest_in;
                        hold_n = 1'b0;
                    end else if (msg_in == MSG_NONE && starved) begin
                        mode_n      = MODE_TAIL;
                        dest_n      = starve_dest;
                        msg_n       = MSG_REQ;
                        cdest_n     = starve_dest;
                        req_written = 1'b1;
                    end
                end
                MODE_TAIL: begin
                    if (msg_in == MSG_SAT && hdr_cdest_in == dest_q) begin
                        mode_n = MODE_FREE;
                        msg_n  = MSG_GNT;
                    end
                end
                MODE_LIMITED: begin
                    if (msg_in == MSG_GNT && hdr_cdest_in == dest_q) begin
                        mode_n = MODE_FREE;
                        hold_n = 1'b0;
                    end else if (msg_in == MSG_SAT && hdr_cdest_in == dest_q &&
                                 lim_active && !hold_q) begin
                        hold_n  = 1'b1;
                        msg_n   = MSG_NONE;
                        cdest_n = '0;
                    end else if (hold_q && !lim_active && msg_in == MSG_NONE) begin
                        hold_n  = 1'b0;
                        msg_n   = MSG_SAT;
                        cdest_n = dest_q;
                    end
                end
                MODE_HEAD: begin
                    if (msg_in == MSG_GNT && hdr_cdest_in == my_addr) begin
                        mode_n  = MODE_FREE;
                        msg_n   = MSG_NONE;
                        cdest_n = '0;
                    end
                end
                default: mode_n = MODE_FREE;
            endcase
        end
    end

    // Mode, destination and held-token registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FREE;
            dest_q <= '0;
            hold_q <= 1'b0;
        end else begin
            mode_q <= mode_n;
            dest_q <= dest_n;
            hold_q <= hold_n;
        end
    end

    // Registered header rewrite, updated on each strobed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_out_valid <= 1'b0;
            hdr_cmsg_out  <= MSG_NONE;
            hdr_cdest_out <= '0;
        end else begin
            hdr_out_valid <= slot_valid;
            if (slot_valid) begin
                hdr_cmsg_out  <= msg_n;
                hdr_cdest_out <= cdest_n;
            end
        end
    end
endmodule

// File: rtl/cgc_node_ctrl.sv
// Top of the per-node collision controller: starvation counter,
// quota tracker and mode machine. One slot header per slot_valid strobe.
module cgc_node_ctrl
    import cgc_pkg::*;
#(
    parameter int NODE_W = 4,
    parameter int QD     = 8,
    parameter int QUOTA  = 4,
    localparam int NDEST = 1 << NODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NODE_W-1:0] my_addr,
    input  logic              slot_valid,
    input  logic [1:0]        hdr_cmsg_in,
    input  logic [NODE_W-1:0] hdr_cdest_in,
    input  logic              blocked,
    input  logic [NODE_W-1:0] blocked_dest,
    input  logic              tx_done,
    input  logic [NODE_W-1:0] tx_dest,
    input  logic [NDEST-1:0]  q_nonempty,
    output logic              hdr_out_valid,
    output logic [1:0]        hdr_cmsg_out,
    output logic [NODE_W-1:0] hdr_cdest_out,
    output logic [NDEST-1:0]  tx_en_mask,
    output logic [1:0]        ctl_state
);
    mode_e             mode;
    logic [NODE_W-1:0] lim_dest, starve_dest;
    logic              starved, req_written, lim_active;

    assign ctl_state = mode;

    cgc_delay_counter #(.NODE_W(NODE_W), .QD(QD)) u_delay (
        .clk(clk), .rst_n(rst_n),
        .count_en(mode == MODE_FREE), .slot_valid(slot_valid),
        .blocked(blocked), .blocked_dest(blocked_dest),
        .delivered(tx_done), .clear(req_written),
        .starved(starved), .starve_dest(starve_dest)
    );

    cgc_quota_tracker #(.NODE_W(NODE_W), .QUOTA(QUOTA)) u_quota (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid),
        .limited(mode == MODE_LIMITED), .lim_dest(lim_dest),
        .tx_done(tx_done), .tx_dest(tx_dest), .q_nonempty(q_nonempty),
        .lim_active(lim_active), .tx_en_mask(tx_en_mask)
    );

    cgc_ctrl_fsm #(.NODE_W(NODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .my_addr(my_addr),
        .hdr_cmsg_in(hdr_cmsg_in), .hdr_cdest_in(hdr_cdest_in),
        .starved(starved), .starve_dest(starve_dest), .lim_active(lim_active),
        .mode(mode), .lim_dest(lim_dest), .req_written(req_written),
        .hdr_out_valid(hdr_out_valid), .hdr_cmsg_out(hdr_cmsg_out),
        .hdr_cdest_out(hdr_cdest_out)
    );
endmodule

// File: rtl/cgc_node_ctrl_checker.sv
// Port-level properties of the collision controller, bound to the top.
module cgc_node_ctrl_checker #(
    parameter int NODE_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   slot_valid,
    input logic [NODE_W-1:0]      my_addr,
    input logic [1:0]             hdr_cmsg_in,
    input logic [NODE_W-1:0]      hdr_cdest_in,
    input logic                   hdr_out_valid,
    input logic [1:0]             hdr_cmsg_out,
    input logic [1:0]             ctl_state,
    input logic [(1<<NODE_W)-1:0] tx_en_mask
);
    AST_MASK_FULL_OUTSIDE_LIMITED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state != 2'd2) |-> (&tx_en_mask)); // R7
    AST_MASK_ONE_BAR: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~tx_en_mask) <= 1); // R7
    AST_MODE_ONLY_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_valid |=> $stable(ctl_state)); // R2
    AST_REQ_ENTERS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_out_valid && hdr_cmsg_out == 2'd1 && $past(hdr_cmsg_in) == 2'd0)
        |-> ctl_state == 2'd1); // R3
    AST_HEAD_ANSWERS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && ctl_state == 2'd0 && hdr_cmsg_in == 2'd1 && hdr_cdest_in == my_addr)
        |=> (ctl_state == 2'd3 && hdr_cmsg_out == 2'd2)); // R9
    AST_GNT_FROM_TAIL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_out_valid && hdr_cmsg_out == 2'd3 && $past(ctl_state) == 2'd1)
        |-> ctl_state == 2'd0); // R10
endmodule

bind cgc_node_ctrl cgc_node_ctrl_checker #(.NODE_W(NODE_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .my_addr(my_addr),
    .hdr_cmsg_in(hdr_cmsg_in), .hdr_cdest_in(hdr_cdest_in),
    .hdr_out_valid(hdr_out_valid), .hdr_cmsg_out(hdr_cmsg_out),
    .ctl_state(ctl_state), .tx_en_mask(tx_en_mask)
);

// File: tb/cgc_node_ctrl_test.sv
module cgc_node_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NODE_W = 3;
    localparam int QD     = 3;
    localparam int QUOTA  = 2;
    localparam int NDEST  = 1 << NODE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NODE_W-1:0] my_addr = 3'd5;
    logic              slot_valid = 1'b0;
    logic [1:0]        hdr_cmsg_in = 2'd0;
    logic [NODE_W-1:0] hdr_cdest_in = '0;
    logic              blocked = 1'b0;
    logic [NODE_W-1:0] blocked_dest = '0;
    logic              tx_done = 1'b0;
    logic [NODE_W-1:0] tx_dest = '0;
    logic [NDEST-1:0]  q_nonempty = '0;
    logic              hdr_out_valid;
    logic [1:0]        hdr_cmsg_out;
    logic [NODE_W-1:0] hdr_cdest_out;
    logic [NDEST-1:0]  tx_en_mask;
    logic [1:0]        ctl_state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cgc_node_ctrl #(.NODE_W(NODE_W), .QD(QD), .QUOTA(QUOTA)) uut (
        .clk(clk), .rst_n(rst_n), .my_addr(my_addr), .slot_valid(slot_valid),
        .hdr_cmsg_in(hdr_cmsg_in), .hdr_cdest_in(hdr_cdest_in),
        .blocked(blocked), .blocked_dest(blocked_dest),
        .tx_done(tx_done), .tx_dest(tx_dest), .q_nonempty(q_nonempty),
        .hdr_out_valid(hdr_out_valid), .hdr_cmsg_out(hdr_cmsg_out),
        .hdr_cdest_out(hdr_cdest_out), .tx_en_mask(tx_en_mask), .ctl_state(ctl_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One strobed slot; outputs are sampled a quarter period after the edge.
    task automatic slot(input int msg, input int dst, input bit blk, input int bdst,
                        input bit tx, input int txd);
        slot_valid   = 1'b1;
        hdr_cmsg_in  = 2'(msg);
        hdr_cdest_in = NODE_W'(dst);
        blocked      = blk;
        blocked_dest = NODE_W'(bdst);
        tx_done      = tx;
        tx_dest      = NODE_W'(txd);
        @(posedge clk);
        #(CLK_PERIOD/4);
        slot_valid = 1'b0;
        blocked    = 1'b0;
        tx_done    = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mode", ctl_state, 0);
        chk("R1 mask", tx_en_mask, 8'hFF);
        chk("R1 strobe", hdr_out_valid, 0);
        chk("R1 code", hdr_cmsg_out, 0);
    endtask

    task automatic t_forward();
        slot(2, 2, 0, 0, 0, 0);
        chk("R2 strobe", hdr_out_valid, 1);
        chk("R2 code", hdr_cmsg_out, 2);
        chk("R2 dest", hdr_cdest_out, 2);
        chk("R2 mode", ctl_state, 0);
        @(posedge clk); #(CLK_PERIOD/4);
        chk("R2 strobe idle", hdr_out_valid, 0);
    endtask

    task automatic t_starve_and_tail();
        slot(0, 0, 1, 3, 0, 0);
        slot(0, 0, 1, 3, 0, 0);
        slot(0, 0, 0, 0, 1, 1);
        chk("R4 delivery no req", hdr_cmsg_out, 0);
        slot(0, 0, 1, 3, 0, 0);
        slot(0, 0, 1, 3, 0, 0);
        chk("R4 split run no req", hdr_cmsg_out, 0);
        chk("R4 still free", ctl_state, 0);
        slot(0, 0, 1, 3, 0, 0);
        chk("R3 req code", hdr_cmsg_out, 1);
        chk("R3 req dest", hdr_cdest_out, 3);
        chk("R3 tail mode", ctl_state, 1);
        slot(2, 6, 0, 0, 0, 0);
        chk("R10 other sat forwarded", hdr_cmsg_out, 2);
        chk("R10 stays tail", ctl_state, 1);
        slot(2, 3, 0, 0, 0, 0);
        chk("R10 gnt code", hdr_cmsg_out, 3);
        chk("R10 gnt dest", hdr_cdest_out, 3);
        chk("R10 free", ctl_state, 0);
    endtask

    task automatic t_deferred_req();
        slot(0, 0, 1, 6, 0, 0);
        slot(0, 0, 1, 6, 0, 0);
        slot(3, 1, 1, 6, 0, 0);
        chk("R5 occupied forwarded", hdr_cmsg_out, 3);
        chk("R5 occupied dest", hdr_cdest_out, 1);
        chk("R5 still free", ctl_state, 0);
        slot(0, 0, 0, 0, 0, 0);
        chk("R5 late req", hdr_cmsg_out, 1);
        chk("R5 late dest", hdr_cdest_out, 6);
        chk("R5 tail", ctl_state, 1);
        slot(2, 6, 0, 0, 0, 0);
        chk("R5 back free", ctl_state, 0);
    endtask

    task automatic t_limited_quota();
        q_nonempty = 8'h04;
        slot(1, 2, 0, 0, 0, 0);
        chk("R6 req forwarded", hdr_cmsg_out, 1);
        chk("R6 limited", ctl_state, 2);
        chk("R7 active mask", tx_en_mask, 8'hFF);
        slot(0, 0, 0, 0, 1, 2);
        slot(0, 0, 0, 0, 1, 7);
        chk("R7 one sent still on", tx_en_mask, 8'hFF);
        slot(0, 0, 0, 0, 1, 2);
        chk("R7 quota used bar", tx_en_mask, 8'hFB);
        slot(2, 2, 0, 0, 0, 0);
        chk("R8 inactive forwards sat", hdr_cmsg_out, 2);
        chk("R8 forward dest", hdr_cdest_out, 2);
        slot(3, 2, 0, 0, 0, 0);
        chk("R11 gnt forwarded", hdr_cmsg_out, 3);
        chk("R11 free", ctl_state, 0);
        chk("R11 mask full", tx_en_mask, 8'hFF);
        slot(1, 2, 0, 0, 0, 0);
        chk("R11 fresh quota", tx_en_mask, 8'hFF);
        slot(3, 2, 0, 0, 0, 0);
        chk("R11 free again", ctl_state, 0);
    endtask

    task automatic t_hold_sat();
        q_nonempty = 8'h10;
        slot(1, 4, 0, 0, 0, 0);
        slot(2, 4, 0, 0, 0, 0);
        chk("R8 sat absorbed", hdr_cmsg_out, 0);
        slot(0, 0, 0, 0, 0, 0);
        chk("R8 still held", hdr_cmsg_out, 0);
        q_nonempty = 8'h00;
        #1;
        chk("R7 empty queue bar", tx_en_mask, 8'hEF);
        slot(0, 0, 0, 0, 0, 0);
        chk("R8 sat released", hdr_cmsg_out, 2);
        chk("R8 release dest", hdr_cdest_out, 4);
        slot(3, 4, 0, 0, 0, 0);
        chk("R11 leaves limited", ctl_state, 0);
    endtask

    task automatic t_head();
        slot(1, 5, 0, 0, 0, 0);
        chk("R9 sat code", hdr_cmsg_out, 2);
        chk("R9 sat dest", hdr_cdest_out, 5);
        chk("R9 head mode", ctl_state, 3);
        slot(3, 5, 0, 0, 0, 0);
        chk("R9 gnt consumed", hdr_cmsg_out, 0);
        chk("R9 free", ctl_state, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b1;
        @(posedge clk); #(CLK_PERIOD/4);
        t_reset();
        t_forward();
        t_starve_and_tail();
        t_deferred_req();
        t_limited_quota();
        t_hold_sat();
        t_head();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule